// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block collects interrupt requests for a small interrupt controller with 64 interrupt IDs and delivers them to two CPU interfaces. It holds a set of state bits for every ID: an enable bit, a pending bit, a trigger mode (level or edge), an 8-bit priority and a CPU target mask. IDs 0–15 are raised by software. IDs 16–31 are private to the cores. IDs 32–63 are shared. Hardware requests for IDs 16–63 arrive on an asynchronous input vector. Each bit of that vector is synchronised and then latches the pending bit of its ID, by level or by rising edge as the ID's trigger mode selects.

Software reaches all state through a single-cycle 32-bit register port that uses word addresses. Enable and pending bits have separate set and clear windows, so that software never has to read, modify and write them back. A software-interrupt register raises IDs 0–15 on any chosen set of CPUs, and each CPU keeps its own copy of those pending bits. For every CPU, an arbiter presents the enabled, pending, targeted ID that has the lowest priority value. A global forwarding bit can silence all CPU interfaces at once.

Top module: `intr_distributor`

## Requirements
- R1: After a synchronous reset the following are all zero: the control register, every enable bit, every pending bit, all priorities and all targets. IDs 16–63 are level-triggered, and `irq_req` is low on every CPU.
- R2: Enable bits are read through either of two windows: the set window (words 0x040 + ID/32) and the clear window (words 0x060 + ID/32), with the ID at bit ID mod 32. Writing a 1 to a bit in the set window enables that ID, and writing a 1 in the clear window disables it. Zero bits change nothing.
- R3: Pending bits use the same layout in two more windows: the set window at 0x080 + ID/32 and the clear window at 0x0A0 + ID/32. A write of 1 sets or clears the bit, and reading either window returns the pending state. For IDs 0–15, reading returns the OR over all CPUs, and a set or clear write acts on every CPU.
- R4: The trigger field of an ID is 2 bits wide, in word 0x300 + ID/16 at bit pair (ID mod 16)*2. The upper bit of the pair is 1 for edge and 0 for level. The lower bit always reads 0. IDs 0–15 always read as edge (0xAAAAAAAA), and writes to their fields are ignored.
- R5: Priority is stored in words 0x100 + ID/4 and the target in words 0x200 + ID/4, one byte per ID at byte lane ID mod 4. A target byte keeps only bit c for CPU c (bits 0–1), and its other bits read 0.
- R6: When an ID is edge-triggered, a rising edge on its input latches pending. The bit stays set after the input falls, until software clears it. If a hardware set and a software clear land in the same cycle, the set wins.
- R7: When an ID is level-triggered, pending is set in every cycle that its input is high. A clear written while the input is still high therefore has no effect. After the input falls, the bit stays latched until it is cleared.
- R8: A write to word 0x3C0 raises a software interrupt. Bits 3:0 give the ID, and bits 17:16 give the CPU mask. That ID becomes pending for each CPU whose mask bit is 1, and only for that CPU.
- R9: Bit 0 of the control word 0x000 enables forwarding. While it is 0, `irq_req` is low on every CPU.
- R10: The read-only word 0x001 returns 1 in bits 4:0, which is (1+1)*32 = 64 IDs.
- R11: A CPU is offered an ID only if forwarding is on and the ID is enabled, pending for that CPU, and (for IDs 16 and above) targeted at it. The lowest priority value wins, and a tie goes to the lowest ID. When no ID qualifies, `irq_id` is 0.
- R12: `reg_rdata` reflects `reg_addr` in the same cycle. A write takes effect at the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_in | input | 48 | Asynchronous hardware requests; bit k belongs to ID k+16 |
| irq_req | output | 2 | One bit per CPU: an ID is being offered |
| irq_id | output | 12 | Offered ID, 6 bits per CPU, CPU c at bits 6c+5:6c |

## Verification
Two functions can act on the same pending bit in the same cycle: the hardware edge detector setting it and a software write to the clear window. The bench raises an edge-configured input and places the clear write so that it is sampled at exactly the edge where the synchronised rising edge is latched. It then reads the pending window and expects the bit to be set. Level-triggered IDs get the same overlap while their input is held high, and the pending bit must survive the clear.

// File: rtl/dist_pkg.sv
package dist_pkg;
    localparam int DEF_NUM_ID   = 64;
    localparam int DEF_NUM_CPU  = 2;
    localparam int SGI_COUNT    = 16;
    localparam int SGI_W        = $clog2(SGI_COUNT);
    localparam int SGI_MASK_LSB = 16;
    localparam int PRIO_W       = 8;
    localparam int ADDR_W       = 10;

    localparam logic [ADDR_W-1:0] A_CTRL   = 10'h000;
    localparam logic [ADDR_W-1:0] A_TYPE   = 10'h001;
    localparam logic [ADDR_W-1:0] A_EN_SET = 10'h040;
    localparam logic [ADDR_W-1:0] A_EN_CLR = 10'h060;
    localparam logic [ADDR_W-1:0] A_PD_SET = 10'h080;
    localparam logic [ADDR_W-1:0] A_PD_CLR = 10'h0A0;
    localparam logic [ADDR_W-1:0] A_PRIO   = 10'h100;
    localparam logic [ADDR_W-1:0] A_TGT    = 10'h200;
    localparam logic [ADDR_W-1:0] A_CFG    = 10'h300;
    localparam logic [ADDR_W-1:0] A_SGI    = 10'h3C0;

    typedef enum logic [3:0] {
        W_NONE, W_CTRL, W_TYPE, W_EN_SET, W_EN_CLR,
        W_PD_SET, W_PD_CLR, W_PRIO, W_TGT, W_CFG, W_SGI
    } win_e;

    typedef struct packed {
        win_e       win;
        logic [5:0] word;
    } decode_t;

    // Maps a word address onto a register window and the word offset inside it.
    function automatic decode_t decode(input logic [ADDR_W-1:0] a);
        decode_t d;
        d.win  = W_NONE;
        d.word = a[5:0];
        if (a == A_CTRL)                  d.win = W_CTRL;
        else if (a == A_TYPE)             d.win = W_TYPE;
        else if (a == A_SGI)              d.win = W_SGI;
        else if (a[9:5] == A_EN_SET[9:5]) begin d.win = W_EN_SET; d.word = {1'b0, a[4:0]}; end
        else if (a[9:5] == A_EN_CLR[9:5]) begin d.win = W_EN_CLR; d.word = {1'b0, a[4:0]}; end
        else if (a[9:5] == A_PD_SET[9:5]) begin d.win = W_PD_SET; d.word = {1'b0, a[4:0]}; end
        else if (a[9:5] == A_PD_CLR[9:5]) begin d.win = W_PD_CLR; d.word = {1'b0, a[4:0]}; end
        else if (a[9:6] == A_PRIO[9:6])   d.win = W_PRIO;
        else if (a[9:6] == A_TGT[9:6])    d.win = W_TGT;
        else if (a[9:6] == A_CFG[9:6])    d.win = W_CFG;
        return d;
    endfunction
endpackage

// File: rtl/dist_irq_sync.sv
module dist_irq_sync #(
    parameter int WIDTH = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] irq_async,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= irq_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level_o = sync_q;
    assign rise_o  = sync_q & ~prev_q;

    // A rising edge is reported for one cycle only (edge latching, R6).
    assert_rise_single_R6: assert property (@(posedge clk) disable iff (rst)
        (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/dist_arbiter.sv
module dist_arbiter #(
    parameter int NUM_ID = 64,
    parameter int PRIO_W = 8,
    localparam int ID_W  = $clog2(NUM_ID)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_ID-1:0]              cand_i,
    input  logic [NUM_ID-1:0][PRIO_W-1:0]  prio_i,
    output logic                           valid_o,
    output logic [ID_W-1:0]                id_o
);
    logic              best_v;
    logic [PRIO_W-1:0] best_p;
    logic [ID_W-1:0]   best_id;

    // Ascending scan with strict compare: lower value wins, ties keep the lower ID.
    always_comb begin
        best_v  = 1'b0;
        best_p  = '0;
        best_id = '0;
        for (int i = 0; i < NUM_ID; i++) begin
            if (cand_i[i] && (!best_v || prio_i[i] < best_p)) begin
                best_v  = 1'b1;
                best_p  = prio_i[i];
                best_id = ID_W'(i);
            end
        end
    end

    assign valid_o = best_v;
    assign id_o    = best_id;

    assert_winner_is_candidate_R11: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> cand_i[id_o]);
    assert_idle_zero_id_R11: assert property (@(posedge clk) disable iff (rst)
        (cand_i == '0) |-> (!valid_o && id_o == '0));
endmodule

// File: rtl/intr_distributor.sv
module intr_distributor
    import dist_pkg::*;
#(
    parameter int NUM_ID  = DEF_NUM_ID,
    parameter int NUM_CPU = DEF_NUM_CPU,
    localparam int ID_W   = $clog2(NUM_ID),
    localparam int HW_IRQ = NUM_ID - SGI_COUNT
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    reg_we,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    input  logic [HW_IRQ-1:0]       irq_in,
    output logic [NUM_CPU-1:0]      irq_req,
    output logic [NUM_CPU*ID_W-1:0] irq_id
);
    localparam int W32 = NUM_ID / 32;
    localparam int W16 = NUM_ID / 16;
    localparam int W4  = NUM_ID / 4;
    localparam logic [NUM_ID-1:0] SGI_ONES = {{HW_IRQ{1'b0}}, {SGI_COUNT{1'b1}}};

    decode_t dec;
    assign dec = decode(reg_addr);

    logic                                ctrl_en;
    logic [NUM_ID-1:0]                   en_q, pend_q, edge_q, edge_view, pend_view;
    logic [NUM_CPU-1:0][SGI_COUNT-1:0]   sgi_q;
    logic [NUM_ID-1:0][PRIO_W-1:0]       prio_q;
    logic [NUM_ID-1:0][NUM_CPU-1:0]      tgt_q;
    logic [HW_IRQ-1:0]                   in_lvl, in_rise;

    dist_irq_sync #(.WIDTH(HW_IRQ)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .irq_async (irq_in),
        .level_o   (in_lvl),
        .rise_o    (in_rise)
    );

    assign edge_view = edge_q | SGI_ONES;

    always_comb begin
        pend_view = pend_q;
        for (int c = 0; c < NUM_CPU; c++)
            pend_view[SGI_COUNT-1:0] = pend_view[SGI_COUNT-1:0] | sgi_q[c];
    end

    // Write strobes and hardware set vector
    logic [NUM_ID-1:0]                 en_set_v, en_clr_v, pd_set_v, pd_clr_v, hw_set_v;
    logic [NUM_CPU-1:0][SGI_COUNT-1:0] sgi_set_v;

    always_comb begin
        en_set_v  = '0;
        en_clr_v  = '0;
        pd_set_v  = '0;
        pd_clr_v  = '0;
        hw_set_v  = '0;
        sgi_set_v = '0;
        if (reg_we && int'(dec.word) < W32) begin
            case (dec.win)
                W_EN_SET: en_set_v[int'(dec.word)*32 +: 32] = reg_wdata;
                W_EN_CLR: en_clr_v[int'(dec.word)*32 +: 32] = reg_wdata;
                W_PD_SET: pd_set_v[int'(dec.word)*32 +: 32] = reg_wdata;
                W_PD_CLR: pd_clr_v[int'(dec.word)*32 +: 32] = reg_wdata;
                default: ;
            endcase
        end
        if (reg_we && dec.win == W_SGI) begin
            for (int c = 0; c < NUM_CPU; c++)
                if (reg_wdata[SGI_MASK_LSB+c])
                    sgi_set_v[c][reg_wdata[SGI_W-1:0]] = 1'b1;
        end
        for (int i = SGI_COUNT; i < NUM_ID; i++)
            hw_set_v[i] = edge_view[i] ? in_rise[i-SGI_COUNT] : in_lvl[i-SGI_COUNT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en <= 1'b0;
            en_q    <= '0;
            pend_q  <= '0;
            edge_q  <= '0;
            sgi_q   <= '0;
            prio_q  <= '0;
            tgt_q   <= '0;
        end else begin
            en_q   <= (en_q | en_set_v) & ~en_clr_v;
            // set sources are ORed after the clear: a same-cycle set wins
            pend_q <= ((pend_q & ~pd_clr_v) | pd_set_v | hw_set_v) & ~SGI_ONES;
            for (int c = 0; c < NUM_CPU; c++)
                sgi_q[c] <= (sgi_q[c] & ~pd_clr_v[SGI_COUNT-1:0])
                          | pd_set_v[SGI_COUNT-1:0] | sgi_set_v[c];
            if (reg_we && dec.win == W_CTRL)
                ctrl_en <= reg_wdata[0];
            if (reg_we && dec.win == W_PRIO && int'(dec.word) < W4)
                for (int b = 0; b < 4; b++)
                    prio_q[int'(dec.word)*4+b] <= reg_wdata[b*8 +: PRIO_W];
            if (reg_we && dec.win == W_TGT && int'(dec.word) < W4)
                for (int b = 0; b < 4; b++)
                    tgt_q[int'(dec.word)*4+b] <= reg_wdata[b*8 +: NUM_CPU];
            if (reg_we && dec.win == W_CFG && int'(dec.word) < W16)
                for (int k = 0; k < 16; k++)
                    if (int'(dec.word)*16 + k >= SGI_COUNT)
                        edge_q[int'(dec.word)*16+k] <= reg_wdata[2*k+1];
        end
    end

    // Read mux, same cycle as the address
    always_comb begin
        reg_rdata = '0;
        case (dec.win)
            W_CTRL: reg_rdata[0] = ctrl_en;
            W_TYPE: reg_rdata[4:0] = 5'(W32 - 1);
            W_EN_SET, W_EN_CLR:
                if (int'(dec.word) < W32) reg_rdata = en_q[int'(dec.word)*32 +: 32];
            W_PD_SET, W_PD_CLR:
                if (int'(dec.word) < W32) reg_rdata = pend_view[int'(dec.word)*32 +: 32];
            W_PRIO:
                if (int'(dec.word) < W4)
                    for (int b = 0; b < 4; b++)
                        reg_rdata[b*8 +: PRIO_W] = prio_q[int'(dec.word)*4+b];
            W_TGT:
                if (int'(dec.word) < W4)
                    for (int b = 0; b < 4; b++)
                        reg_rdata[b*8 +: NUM_CPU] = tgt_q[int'(dec.word)*4+b];
            W_CFG:
                if (int'(dec.word) < W16)
                    for (int k = 0; k < 16; k++)
                        reg_rdata[2*k+1] = edge_view[int'(dec.word)*16+k];
            default: ;
        endcase
    end

    // One candidate vector and arbiter per CPU interface
    genvar gc;
    generate
        for (gc = 0; gc < NUM_CPU; gc++) begin : g_cpu
            logic [NUM_ID-1:0] cand;
            always_comb begin
                cand = '0;
                for (int i = 0; i < SGI_COUNT; i++)
                    cand[i] = ctrl_en && en_q[i] && sgi_q[gc][i];
                for (int i = SGI_COUNT; i < NUM_ID; i++)
                    cand[i] = ctrl_en && en_q[i] && pend_q[i] && tgt_q[i][gc];
            end
            dist_arbiter #(.NUM_ID(NUM_ID), .PRIO_W(PRIO_W)) u_arb (
                .clk     (clk),
                .rst     (rst),
                .cand_i  (cand),
                .prio_i  (prio_q),
                .valid_o (irq_req[gc]),
                .id_o    (irq_id[gc*ID_W +: ID_W])
            );
        end
    endgenerate

    assert_forward_gate_R9: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |-> (irq_req == '0));
    assert_enable_set_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == A_EN_SET && reg_wdata[0]) |=> en_q[0]);
    assert_enable_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == A_EN_CLR && reg_wdata[0]) |=> !en_q[0]);
    assert_sgi_cpu0_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == A_SGI && reg_wdata[SGI_MASK_LSB] && reg_wdata[SGI_W-1:0] == '0)
        |=> sgi_q[0][0]);
    assert_edge_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (edge_view[SGI_COUNT] && in_rise[0]) |=> pend_q[SGI_COUNT]);
endmodule

// File: tb/sim_intr_distributor.sv
`timescale 1ns/1ps
module sim_intr_distributor;
    localparam logic [9:0] A_CTRL = 10'h000, A_TYPE = 10'h001, A_EN_SET = 10'h040,
                           A_EN_CLR = 10'h060, A_PD_SET = 10'h080, A_PD_CLR = 10'h0A0,
                           A_PRIO = 10'h100, A_TGT = 10'h200, A_CFG = 10'h300, A_SGI = 10'h3C0;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [9:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [47:0] irq_in;
    logic [1:0]  irq_req;
    logic [11:0] irq_id;

    intr_distributor u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
        .irq_req(irq_req), .irq_id(irq_id)
    );

    always #4 clk = ~clk;

    typedef struct {
        int          kind;   // -1: register read, else CPU index
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    event  smp;
    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;

    function automatic logic [31:0] irqv(input logic v, input int id);
        return {25'd0, v, 6'(id)};
    endfunction

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic expect_rd(input logic [9:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        reg_addr = a;
        q.push_back('{-1, e, tag});
        #1 ->smp;
    endtask

    task automatic expect_irq(input int c, input logic [31:0] e, input string tag);
        @(negedge clk);
        q.push_back('{c, e, tag});
        #1 ->smp;
    endtask

    // Monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            @(smp);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                if (it.kind < 0) act = reg_rdata;
                else act = {25'd0, irq_req[it.kind], irq_id[it.kind*6 +: 6]};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; irq_in = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_rd(A_CTRL, 32'h0, "R1 control");
        expect_rd(A_EN_SET + 1, 32'h0, "R1 enable");
        expect_rd(A_PD_SET + 1, 32'h0, "R1 pending");
        expect_rd(A_CFG + 2, 32'h0, "R1 level config");
        expect_rd(A_PRIO + 8, 32'h0, "R1 priority");
        expect_irq(0, irqv(0, 0), "R1 cpu0 idle");
        // R10 type, R12 same-cycle read
        expect_rd(A_TYPE, 32'h1, "R10 type");

        // R4 trigger configuration
        expect_rd(A_CFG, 32'hAAAAAAAA, "R4 fixed edge");
        wr(A_CFG, 32'h0);
        expect_rd(A_CFG, 32'hAAAAAAAA, "R4 write ignored");
        wr(A_CFG + 3, 32'hFFFFFFFF);
        expect_rd(A_CFG + 3, 32'hAAAAAAAA, "R4 low bit zero");
        wr(A_CFG + 3, 32'h0);
        wr(A_CFG + 2, 32'h2);
        expect_rd(A_CFG + 2, 32'h2, "R4 id32 edge");

        // R2 enable windows
        wr(A_EN_SET + 1, 32'h5);
        expect_rd(A_EN_SET + 1, 32'h5, "R2 set view");
        expect_rd(A_EN_CLR + 1, 32'h5, "R2 clear view");
        wr(A_EN_CLR + 1, 32'h4);
        expect_rd(A_EN_SET + 1, 32'h1, "R2 clear");
        wr(A_EN_SET + 1, 32'h0);
        wr(A_EN_CLR + 1, 32'h0);
        expect_rd(A_EN_SET + 1, 32'h1, "R2 zero bits");

        // R5 byte lanes
        wr(A_PRIO + 8, 32'h10202030);
        expect_rd(A_PRIO + 8, 32'h10202030, "R5 priority");
        wr(A_TGT + 8, 32'hFFFFFFFF);
        expect_rd(A_TGT + 8, 32'h03030303, "R5 target width");
        wr(A_TGT + 8, 32'h02010103);
        expect_rd(A_TGT + 8, 32'h02010103, "R5 target");

        // R3 pending windows
        wr(A_PD_SET + 1, 32'h100);
        expect_rd(A_PD_SET + 1, 32'h100, "R3 set");
        expect_rd(A_PD_CLR + 1, 32'h100, "R3 clear view");
        wr(A_PD_CLR + 1, 32'h100);
        expect_rd(A_PD_SET + 1, 32'h0, "R3 clear");

        // R9 and R11 arbitration
        wr(A_EN_SET + 1, 32'hF);
        wr(A_PD_SET + 1, 32'hE);
        expect_irq(0, irqv(0, 0), "R9 cpu0 gated");
        expect_irq(1, irqv(0, 0), "R9 cpu1 gated");
        wr(A_CTRL, 32'h1);
        expect_irq(0, irqv(1, 33), "R11 tie lowest id");
        expect_irq(1, irqv(1, 35), "R11 target cpu1");
        wr(A_PD_CLR + 1, 32'h2);
        expect_irq(0, irqv(1, 34), "R11 next");
        wr(A_PD_SET + 1, 32'h1);
        expect_irq(0, irqv(1, 34), "R11 priority over id");
        expect_irq(1, irqv(1, 35), "R11 cpu1 priority");
        wr(A_PD_CLR + 1, 32'h8);
        expect_irq(1, irqv(1, 32), "R11 cpu1 fallback");
        wr(A_EN_CLR + 1, 32'h4);
        expect_irq(0, irqv(1, 32), "R11 disabled skipped");
        wr(A_CTRL, 32'h0);
        expect_irq(0, irqv(0, 0), "R9 gate off");
        wr(A_CTRL, 32'h1);
        wr(A_PD_CLR + 1, 32'hFFFFFFFF);
        expect_irq(0, irqv(0, 0), "R3 all cleared");

        // R6 edge on ID 32
        irq_in[16] = 1'b1;
        repeat (4) @(negedge clk);
        expect_rd(A_PD_SET + 1, 32'h1, "R6 edge latched");
        expect_irq(1, irqv(1, 32), "R6 cpu1 sees edge");
        irq_in[16] = 1'b0;
        repeat (4) @(negedge clk);
        expect_rd(A_PD_SET + 1, 32'h1, "R6 held after fall");
        wr(A_PD_CLR + 1, 32'h1);
        expect_rd(A_PD_SET + 1, 32'h0, "R6 cleared");
        // same-cycle edge set and software clear
        @(negedge clk);
        irq_in[16] = 1'b1;
        @(negedge clk);
        wr(A_PD_CLR + 1, 32'h1);
        expect_rd(A_PD_SET + 1, 32'h1, "R6 set wins over clear");
        irq_in[16] = 1'b0;
        repeat (4) @(negedge clk);
        wr(A_PD_CLR + 1, 32'h1);
        expect_rd(A_PD_SET + 1, 32'h0, "R6 final clear");

        // R7 level on ID 33
        irq_in[17] = 1'b1;
        repeat (4) @(negedge clk);
        expect_rd(A_PD_SET + 1, 32'h2, "R7 level set");
        expect_irq(0, irqv(1, 33), "R7 cpu0 level");
        wr(A_PD_CLR + 1, 32'h2);
        expect_rd(A_PD_SET + 1, 32'h2, "R7 clear while high");
        irq_in[17] = 1'b0;
        repeat (4) @(negedge clk);
        expect_rd(A_PD_SET + 1, 32'h2, "R7 latched after fall");
        wr(A_PD_CLR + 1, 32'h2);
        expect_rd(A_PD_SET + 1, 32'h0, "R7 cleared");

        // R8 software interrupts
        wr(A_EN_SET, 32'h8);
        wr(A_SGI, (32'h2 << 16) | 32'h3);
        expect_irq(1, irqv(1, 3), "R8 cpu1 raised");
        expect_irq(0, irqv(0, 0), "R8 cpu0 masked");
        expect_rd(A_PD_SET, 32'h8, "R8 pending view");
        wr(A_SGI, (32'h1 << 16) | 32'h5);
        expect_irq(0, irqv(0, 0), "R8 not enabled");
        expect_rd(A_PD_SET, 32'h28, "R8 pending or");
        wr(A_EN_SET, 32'h20);
        expect_irq(0, irqv(1, 5), "R8 cpu0 raised");
        expect_irq(1, irqv(1, 3), "R8 cpu1 unchanged");
        wr(A_PD_CLR, 32'hFFFF);
        expect_irq(0, irqv(0, 0), "R8 cleared cpu0");
        expect_irq(1, irqv(0, 0), "R8 cleared cpu1");

        #20;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule